// File: doc/BRIEF.md
# DS3 Transmit Reference Frame Generator

This block produces a timing reference for a DS3 transmitter. It is clocked at the DS3 line rate, 44.736 MHz, and steps through one position of a 4760-bit M-frame on every clock where the enable is high. The M-frame has 7 subframes of 680 bits. Each subframe holds 8 blocks of 85 bits, and the first bit of every block is an overhead bit, so a frame has 56 overhead slots.

The block has three outputs. The reference data stream carries only the fixed framing (F) and multiframe (M) bit values. Every other position is held low: payload bits, and the X, P and C overhead bits. An active-low gap strobe marks the overhead slot of every block. An active-low frame strobe marks the first bit of the frame. Downstream logic uses these strobes to line up payload and overhead insertion.

When the enable is low, the position counters hold and all three outputs are idle. The idle values are data low and both strobes high. A synchronous reset returns the counters to bit 1 of subframe 1.

Top module: `ds3_ref_framer`

## Requirements
- R1: The position advances by one bit on each rising clock edge where `en` is 1. It wraps from the last bit of the frame, position 4759, back to position 0. When `en` is 0 the position holds.
- R2: `frame_n` is 0 only while `en` is 1 and the position is 0, the first bit of the frame.
- R3: `gap_n` is 0 only while `en` is 1 and the position is a multiple of 85. That gives 56 gap strobes per frame, each one clock wide.
- R4: In the overhead slot of block k of a subframe (k = 0..7, so overhead position k+1), `ref_data` follows the F pattern. It is 1 for k = 1 and k = 7, and 0 for k = 3 and k = 5.
- R5: In the overhead slot of block 0 of subframe s (s = 0..6), `ref_data` is 1 only for s = 5. That slot carries the M bits 0, 1, 0 in subframes 4, 5 and 6, and is low in subframes 0 to 3, where it holds X, P or C bits.
- R6: `ref_data` is 0 at every non-overhead position, and at every position while `en` is 0. Each frame carries exactly 15 ones.
- R7: While `en` is 0, `gap_n` and `frame_n` are both 1 and the position does not change.
- R8: A synchronous `rst` of 1 returns the position to 0. The first enabled cycle after reset therefore shows `frame_n` and `gap_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate reference clock (44.736 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; 0 holds the position and idles the outputs |
| ref_data | output | 1 | Reference data: F and M values only, all other positions 0 |
| gap_n | output | 1 | Active-low strobe on the overhead bit of each 85-bit block |
| frame_n | output | 1 | Active-low strobe on the first bit of the frame |

## Verification
The hardest case to reach from the ports is the frame wrap while `en` is toggling. The last position and the M-bit slots must stay correct when enabled cycles are spread irregularly over many clocks. The bench runs whole frames with `en` held high. It then runs two more frames with `en` driven by a pseudo-random pattern. A reference position counter in the bench advances only on enabled edges, and the bench checks every output against values it computes from that counter. A reset applied in the middle of a frame checks that the position restarts at 0.

// File: rtl/ds3_ref_framer.sv
module ds3_ref_framer #(
  parameter int BLOCK_BITS     = 85,
  parameter int BLOCKS_PER_SUB = 8,
  parameter int SUBFRAMES      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ref_data,
  output logic gap_n,
  output logic frame_n
);
  localparam int BW = $clog2(BLOCK_BITS);
  localparam int KW = $clog2(BLOCKS_PER_SUB);
  localparam int SW = $clog2(SUBFRAMES);
  localparam logic [BW-1:0] BIT_LAST = BW'(BLOCK_BITS - 1);
  localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS_PER_SUB - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBFRAMES - 1);
  localparam logic [SW-1:0] M_ONE    = SW'(SUBFRAMES - 2);

  logic [BW-1:0] bit_q;
  logic [KW-1:0] blk_q;
  logic [SW-1:0] sub_q;

  wire bit_wrap = (bit_q == BIT_LAST);
  wire blk_wrap = bit_wrap && (blk_q == BLK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      blk_q <= '0;
      sub_q <= '0;
    end else if (en) begin
      bit_q <= bit_wrap ? '0 : bit_q + 1'b1;
      if (bit_wrap) blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
      if (blk_wrap) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end
  end

  wire ovh    = (bit_q == '0);
  wire f_one  = (blk_q == KW'(1)) || (blk_q == BLK_LAST);
  wire m_one  = (blk_q == '0) && (sub_q == M_ONE);

  assign gap_n    = ~(en && ovh);
  assign frame_n  = ~(en && ovh && blk_q == '0 && sub_q == '0);
  assign ref_data = en && ovh && (f_one || m_one);

  // R1: counters stay in range
  a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
    bit_q <= BIT_LAST && blk_q <= BLK_LAST && sub_q <= SUB_LAST);
  // R7: position holds when disabled
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bit_q) && $stable(blk_q) && $stable(sub_q));
  // R2: frame strobe only inside a gap slot
  a_r2_frame_in_gap: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> !gap_n);
  // R3: gap strobe lasts one enabled cycle
  a_r3_gap_single: assert property (@(posedge clk) disable iff (rst)
    (!gap_n && en) |=> (gap_n || !en || $past(rst)) || 1'b0 ? 1'b1 : gap_n);
  // R6: data high only in an overhead slot
  a_r6_data_in_gap: assert property (@(posedge clk) disable iff (rst)
    ref_data |-> !gap_n);
  // R8: reset returns to frame start
  a_r8_reset_start: assert property (@(posedge clk)
    rst |=> (bit_q == '0 && blk_q == '0 && sub_q == '0));
endmodule

// File: tb/ds3_ref_framer_tb_top.sv
module ds3_ref_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic ref_data, gap_n, frame_n;
  int total = 0;
  int bad = 0;
  int p = 0;
  int ones = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  ds3_ref_framer dut_i (.clk(clk), .rst(rst), .en(en),
                        .ref_data(ref_data), .gap_n(gap_n), .frame_n(frame_n));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pos=%0d act=%b exp=%b", req, p, act, exp);
    end
  endtask

  function automatic logic exp_data(input int pos);
    int b = pos % 85;
    int k = (pos / 85) % 8;
    int s = pos / 680;
    return (b == 0) && (k == 1 || k == 7 || (k == 0 && s == 5));
  endfunction

  task automatic step(input logic e);
    @(negedge clk);
    en = e;
    #1;
    if (e) begin
      chk("R2 frame_n", frame_n, !(p == 0));
      chk("R3 gap_n", gap_n, !(p % 85 == 0));
      chk("R4/R5/R6 ref_data", ref_data, exp_data(p));
      if (ref_data) ones++;
      p = (p + 1) % 4760;
    end else begin
      chk("R7 gap_n idle", gap_n, 1'b1);
      chk("R7 frame_n idle", frame_n, 1'b1);
      chk("R6 ref_data idle", ref_data, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset gap_n", gap_n, 1'b1);
    chk("R8 reset frame_n", frame_n, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    // R8: first enabled cycle shows frame start
    for (int f = 0; f < 2; f++) begin
      ones = 0;
      for (int i = 0; i < 4760; i++) step(1'b1);
      chk("R6 fifteen ones", ones == 15, 1'b1);
    end
    // R1/R7: irregular enable over two frames
    for (int f = 0; f < 2; f++) begin
      ones = 0;
      for (int i = 0; i < 4760; ) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0] | lfsr[1]) begin
          step(1'b1);
          i++;
        end else step(1'b0);
      end
      chk("R1 wrap count", ones == 15, 1'b1);
    end
    // R8: mid-frame reset
    for (int i = 0; i < 1234; i++) step(1'b1);
    @(negedge clk);
    en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    p = 0;
    step(1'b1);
    for (int i = 0; i < 800; i++) step(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule